// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host port and an external asynchronous static RAM of 512K bytes. The RAM has active-low chip select, output enable and write strobe, plus a shared data bus. The block turns one host request at a time into a correctly timed pin sequence.

A read holds select and output enable low, with the strobe high, for the access window. It then captures the returned byte and gives the host a one-cycle response pulse. A write goes through four steps:

- It first keeps output enable high for a turnaround interval with the data bus undriven.
- It then lowers the write strobe while driving the data.
- It raises the strobe to commit the byte.
- It keeps driving for one more cycle to provide data hold.

Address and write data are latched when a request is accepted. They stay unchanged for as long as chip select is low. Between operations chip select is high, so the RAM idles in standby.

Every time window is given in picoseconds as a parameter, alongside the clock period. Each window becomes a cycle count by rounding up, with a floor of one cycle.

Top module: `async_sram_ctl`

## Requirements
- R1: After reset, and in idle, chip select, output enable and write strobe are high (1), the data driver is off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only on a clock edge where `req_ready` is 1. `req_ready` is 0 from the cycle after acceptance until the operation completes. A request pulsed while busy causes no memory access.
- R3: A read keeps chip select low, output enable low and the write strobe high for exactly READ_CYC consecutive cycles (2 with default parameters).
- R4: The data bus value present in the last read cycle is returned on `rsp_rdata`, together with a `rsp_valid` pulse exactly one cycle wide.
- R5: Before the write strobe falls, at least TURN_CYC cycles pass with chip select low, output enable high, the strobe high and the driver off.
- R6: The write strobe is low for exactly PULSE_CYC = max(WP_CYC, DW_CYC) consecutive cycles (2 with defaults), with chip select low and the data driver on throughout. The byte is written into the memory when the strobe rises.
- R7: The data driver is never on while output enable is low. It stays on for the cycle after the write strobe rises.
- R8: While chip select stays low, the memory address does not change, and neither do the driven data.
- R9: Each window in picoseconds becomes ceil(window / CLK_PS) cycles, and at least one. With a 10 ns clock: 20 ns read gives 2, 12 ns pulse gives 2, 9 ns data setup gives 1, 5 ns turnaround gives 1.
- R10: Between two back-to-back operations there is at least one cycle with chip select high and `req_ready` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Byte address |
| req_wdata | input | DATA_W (8) | Byte to write |
| req_ready | output | 1 | Controller idle, request taken this edge if valid |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | DATA_W (8) | Captured read byte |
| mem_addr | output | ADDR_W (19) | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dout | output | DATA_W (8) | Data toward the memory |
| mem_dout_en | output | 1 | Enable for the data-bus driver |
| mem_din | input | DATA_W (8) | Data from the memory bus |

## Verification
The bound checker examines the pin-level rules on every cycle:

- The driver never overlaps output enable.
- The strobe is only low with select low and the driver on.
- A turnaround cycle comes before the strobe falls.
- The driver is held after the strobe rises.
- The address and data stay constant under select.
- The strobe width matches PULSE_CYC.
- The response pulse is one cycle wide.

Only the bench scenarios can show the rest: that bytes really land in the memory model and come back on reads, that overwrites replace older contents, that an unwritten location reads as the model's default, and that a request pulsed while busy never reaches the memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_WR_SETUP = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4
    } ctl_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } pin_ctl_t;

    // Round a time window up to whole clock cycles, never below one.
    function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels that belong to each sequencer state.
    function automatic pin_ctl_t decode_pins(input ctl_state_e s);
        pin_ctl_t p;
        case (s)
            ST_RD_ACC:   p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
            ST_WR_SETUP: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
            ST_WR_PULSE: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
            ST_WR_HOLD:  p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
            default:     p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned READ_CYC  = 2,
    parameter int unsigned TURN_CYC  = 1,
    parameter int unsigned PULSE_CYC = 2,
    parameter int unsigned CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             is_write,
    input  logic             timer_done,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output ctl_state_e       state_q,
    output ctl_state_e       state_d
);
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    timer_load = 1'b1;
                    if (is_write) begin
                        state_d   = ST_WR_SETUP;
                        timer_val = CNT_W'(TURN_CYC - 1);
                    end else begin
                        state_d   = ST_RD_ACC;
                        timer_val = CNT_W'(READ_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (timer_done) state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (timer_done) begin
                    state_d    = ST_WR_PULSE;
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(PULSE_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (timer_done) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  ctl_state_e        state_q,
    input  ctl_state_e        state_d,
    input  logic              timer_done,
    input  logic [DATA_W-1:0] mem_din,
    output pin_ctl_t          pins,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic capture;

    // Last cycle of the read window: memory data is settled here.
    assign capture = (state_q == ST_RD_ACC) && timer_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins      <= decode_pins(ST_IDLE);
            mem_addr  <= '0;
            mem_dout  <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            pins      <= decode_pins(state_d);
            rsp_valid <= capture;
            if (accept) begin
                mem_addr <= req_addr;
                mem_dout <= req_wdata;
            end
            if (capture) rsp_rdata <= mem_din;
        end
    end
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W       = 19,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned CLK_PS       = 10000,
    parameter int unsigned RD_ACCESS_PS = 20000,
    parameter int unsigned WP_PS        = 12000,
    parameter int unsigned DW_PS        = 9000,
    parameter int unsigned TURN_PS      = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int unsigned READ_CYC  = ps_to_cycles(RD_ACCESS_PS, CLK_PS);
    localparam int unsigned WP_CYC    = ps_to_cycles(WP_PS, CLK_PS);
    localparam int unsigned DW_CYC    = ps_to_cycles(DW_PS, CLK_PS);
    localparam int unsigned TURN_CYC  = ps_to_cycles(TURN_PS, CLK_PS);
    localparam int unsigned PULSE_CYC = max_u(WP_CYC, DW_CYC);
    localparam int unsigned MAX_CYC   = max_u(max_u(READ_CYC, TURN_CYC), PULSE_CYC);
    localparam int unsigned CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    ctl_state_e       state_q, state_d;
    logic             accept, timer_load, timer_done;
    logic [CNT_W-1:0] timer_val;
    pin_ctl_t         pins;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    sram_ctl_fsm #(
        .READ_CYC (READ_CYC),
        .TURN_CYC (TURN_CYC),
        .PULSE_CYC(PULSE_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .is_write  (req_write),
        .timer_done(timer_done),
        .timer_load(timer_load),
        .timer_val (timer_val),
        .state_q   (state_q),
        .state_d   (state_d)
    );

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .load_val(timer_val),
        .done    (timer_done)
    );

    sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .state_q   (state_q),
        .state_d   (state_d),
        .timer_done(timer_done),
        .mem_din   (mem_din),
        .pins      (pins),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_ce_n    = pins.ce_n;
    assign mem_oe_n    = pins.oe_n;
    assign mem_we_n    = pins.we_n;
    assign mem_dout_en = pins.drive;
endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PULSE_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en
);
    logic [15:0] we_low_q;

    always_ff @(posedge clk) begin
        if (rst || mem_we_n) we_low_q <= '0;
        else                 we_low_q <= we_low_q + 16'd1;
    end

    assert_idle_standby_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_we_n && !mem_dout_en));

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en));

    assert_strobe_ctx_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dout_en));

    assert_strobe_width_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_q == 16'(PULSE_CYC)));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> mem_oe_n);

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dout_en);

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    assert_data_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout));
endmodule

bind async_sram_ctl sram_ctl_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PULSE_CYC(PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dout   (mem_dout),
    .mem_dout_en(mem_dout_en)
);

// File: tb/async_sram_ctl_test.sv
`timescale 1ns/1ps
module async_sram_ctl_test;
    // Expected counts with a 10 ns clock (R9): read 20 ns -> 2, pulse max(12 ns, 9 ns) -> 2
    localparam int EXP_READ  = 2;
    localparam int EXP_PULSE = 2;
    localparam int EXP_TURN  = 1;
    localparam logic [7:0] UNWRITTEN = 8'hEE;

    // {write, addr[18:0], data[7:0], expected read[7:0]}
    localparam int NOPS = 9;
    localparam logic [35:0] OPS [NOPS] = '{
        {1'b1, 19'h00000, 8'hA5, 8'h00},
        {1'b1, 19'h7FFFF, 8'h3C, 8'h00},
        {1'b1, 19'h12345, 8'hFF, 8'h00},
        {1'b0, 19'h00000, 8'h00, 8'hA5},
        {1'b0, 19'h7FFFF, 8'h00, 8'h3C},
        {1'b1, 19'h00000, 8'h00, 8'h00},
        {1'b0, 19'h00000, 8'h00, 8'h00},
        {1'b0, 19'h12345, 8'h00, 8'hFF},
        {1'b0, 19'h55555, 8'h00, UNWRITTEN}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem_model [logic [18:0]];

    always #5 clk = ~clk;

    async_sram_ctl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    // Behavioural memory: byte captured on the strobe's rising edge.
    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0 && mem_dout_en === 1'b1) mem_model[mem_addr] = mem_dout;
    end

    always_comb begin
        mem_din = 8'h00;
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_din = mem_model.exists(mem_addr) ? mem_model[mem_addr] : UNWRITTEN;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_at(input logic [18:0] a);
        return mem_model.exists(a) ? mem_model[a] : UNWRITTEN;
    endfunction

    // Issues one operation and measures its pin sequence at negedges.
    task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                         input logic [7:0] exp);
        int rd_cnt = 0, we_cnt = 0, setup_cnt = 0, viol = 0, hold_bad = 0, addr_bad = 0;
        bit got = 0, prev_we_low = 0, done = 0;
        logic [7:0] got_data = '0;
        logic [18:0] prev_addr = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 busy after accept", req_ready, 0);
        prev_addr = mem_addr;
        for (int i = 0; i < 20 && !done; i++) begin
            if (!mem_ce_n && mem_addr !== prev_addr) addr_bad++;
            prev_addr = mem_addr;
            if (!mem_oe_n && !mem_ce_n && mem_we_n) rd_cnt++;
            if (!mem_we_n) we_cnt++;
            if (we_cnt == 0 && !mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en) setup_cnt++;
            if (mem_dout_en && !mem_oe_n) viol++;
            if (prev_we_low && mem_we_n && !mem_dout_en) hold_bad++;
            prev_we_low = !mem_we_n;
            if (rsp_valid) begin got = 1; got_data = rsp_rdata; end
            if (req_ready && (wr ? (we_cnt > 0) : got)) done = 1;
            else @(negedge clk);
        end
        chk(mem_ce_n, "R10 standby between ops", mem_ce_n, 1);
        chk(viol == 0, "R7 drive while outputs on", viol, 0);
        chk(addr_bad == 0, "R8 address moved under select", addr_bad, 0);
        if (wr) begin
            chk(we_cnt == EXP_PULSE, "R6 R9 strobe width", we_cnt, EXP_PULSE);
            chk(setup_cnt >= EXP_TURN, "R5 turnaround before strobe", setup_cnt, EXP_TURN);
            chk(hold_bad == 0, "R7 data hold after strobe", hold_bad, 0);
            chk(model_at(a) == d, "R6 byte stored", model_at(a), d);
        end else begin
            chk(rd_cnt == EXP_READ, "R3 R9 read window", rd_cnt, EXP_READ);
            chk(got && got_data == exp, "R4 read data", got_data, exp);
            @(negedge clk);
            chk(!rsp_valid, "R4 pulse one cycle", rsp_valid, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en, "R1 pins in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en}, 4'b1110);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R1 idle after reset", {req_ready, rsp_valid}, 2'b10);
        chk(mem_ce_n, "R1 standby after reset", mem_ce_n, 1);

        for (int k = 0; k < NOPS; k++)
            do_op(OPS[k][35], OPS[k][34:16], OPS[k][15:8], OPS[k][7:0]);

        // R2: request pulsed while busy must not reach memory
        begin
            int we_seen = 0;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00000;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h2AAAA; req_wdata = 8'h77;
            @(negedge clk);
            req_valid = 1'b0;
            for (int i = 0; i < 10; i++) begin
                if (!mem_we_n) we_seen++;
                @(negedge clk);
            end
            chk(we_seen == 0, "R2 busy request ignored", we_seen, 0);
        end
        do_op(1'b0, 19'h2AAAA, 8'h00, UNWRITTEN);

        // R10: request held valid across two writes
        begin
            int idle_gap = 0;
            bit seen_first = 0;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00101; req_wdata = 8'h11;
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                if (!mem_we_n) seen_first = 1;
                if (seen_first && req_ready && mem_ce_n) begin
                    idle_gap++;
                    req_addr = 19'h00202; req_wdata = 8'h22;
                end
            end
            req_valid = 1'b0;
            repeat (6) @(negedge clk);
            chk(idle_gap >= 1, "R10 idle cycle between ops", idle_gap, 1);
            chk(model_at(19'h00202) == 8'h22, "R10 second write landed",
                model_at(19'h00202), 8'h22);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule